// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches a seven-pin input port and raises one interrupt request when a pin sees the edge it has been armed for. Each pin has its own edge choice (rising or falling), its own enable, and its own sticky pending flag. Software reaches the three control registers over a small synchronous 8-bit register bus with an address, a write strobe, write data and read data.

The pins are asynchronous to the block clock. Each pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with the sample one cycle older. Each pin's pending flag is a two-state machine. `FLG_IDLE` moves to `FLG_PEND` on the transition SET, which is an active edge on that pin. `FLG_PEND` returns to `FLG_IDLE` on the transition CLEAR, which is a write of 1 to that flag bit in a cycle with no active edge on the pin. In every other case the state holds (the HOLD transition). A new edge therefore always beats a clear. A flag latches whether or not its pin is enabled. The enable masks only the request output.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the polarity register (offset 0x1D), the enable register (offset 0x1E) and the flag register (offset 0x1F) all read 0x00, and `irq_o` is 0.
- R2: The polarity register at offset 0x1D holds bits 6..0. Bit 7 reads 0, so writing 0xFF reads back 0x7F. For pin i, bit i = 1 selects the rising edge and bit i = 0 selects the falling edge. A new setting applies to the next edge that is seen.
- R3: The enable register at offset 0x1E holds bits 6..0, and bit 7 reads 0. Writing 0xFF reads back 0x7F.
- R4: When polarity bit i is 0, a high-to-low change on `pin_in[i]` sets flag bit i (offset 0x1F, bit i).
- R5: When polarity bit i is 1, a low-to-high change on `pin_in[i]` sets flag bit i, and a high-to-low change does not.
- R6: A flag bit is set by its active edge even while its enable bit is 0. In that case `irq_o` stays 0.
- R7: `irq_o` is 1 exactly when some bit i has both flag i and enable i set.
- R8: Writing 1 to flag bit i clears it. Writing 0 leaves it unchanged. A write to the flag register never sets a flag.
- R9: If a write of 1 to flag bit i lands in the same cycle as a new active edge on pin i, the flag ends at 1.
- R10: Reading any register leaves the flags unchanged.
- R11: A pin change applied before clock edge 1 is not visible in the flag after clock edge 2, and is visible after clock edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 7 | Asynchronous port pins |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet on the same flag bit in the same cycle: the edge detector setting it and a bus write of 1 clearing it. The bench provokes this by changing a rising-armed pin and then timing the clearing write to commit on the third clock edge after the change, which is the same edge on which the flag would be set. The result is judged by reading the flag register back: the bit must still be 1. A plain clear with no edge present is checked as well, to show that the clear path works on its own.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // State of one pending flag
    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_t;

endpackage

// File: rtl/pin_irq_sync.sv
// Synchronizer chain plus polarity-selected edge detection, one lane per pin.
module pin_irq_sync #(
    parameter int PIN_N       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] pin_raw,
    input  logic [PIN_N-1:0] pol_rise,
    output logic [PIN_N-1:0] hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [PIN_N-1:0] stage_q [SYNC_STAGES];
    logic [PIN_N-1:0] prev_q;
    logic [PIN_N-1:0] lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) begin
                stage_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_raw;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            prev_q <= stage_q[LAST];
        end
    end

    assign lvl = stage_q[LAST];

    for (genvar i = 0; i < PIN_N; i++) begin : g_lane
        logic went_up;
        logic went_down;
        assign went_up   =  lvl[i] & ~prev_q[i];
        assign went_down = ~lvl[i] &  prev_q[i];
        assign hit[i]    = pol_rise[i] ? went_up : went_down;
    end

endmodule

// File: rtl/pin_irq_flag.sv
// One sticky pending flag, kept as a two-state machine.
module pin_irq_flag
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_i) state_d = FLG_PEND;                 // SET
            end
            FLG_PEND: begin
                if (clr_i && !set_i) state_d = FLG_IDLE;       // CLEAR, else HOLD
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    assign pend_o = (state_q == FLG_PEND);

endmodule

// File: rtl/pin_irq_regs.sv
// Polarity and enable registers, flag clear decode and read multiplexer.
module pin_irq_regs #(
    parameter int         PIN_N   = 7,
    parameter int         DATA_W  = 8,
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] OFS_POL = 8'h1D,
    parameter logic [7:0] OFS_EN  = 8'h1E,
    parameter logic [7:0] OFS_FLG = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [PIN_N-1:0]  flags,
    output logic [PIN_N-1:0]  pol_q,
    output logic [PIN_N-1:0]  en_q,
    output logic [PIN_N-1:0]  clr
);
    localparam int PAD_W = DATA_W - PIN_N;

    logic sel_pol, sel_en, sel_flg;
    logic unused_hi;

    assign sel_pol = (addr == ADDR_W'(OFS_POL));
    assign sel_en  = (addr == ADDR_W'(OFS_EN));
    assign sel_flg = (addr == ADDR_W'(OFS_FLG));

    assign unused_hi = ^wdata[DATA_W-1:PIN_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else if (we) begin
            if (sel_pol) pol_q <= wdata[PIN_N-1:0];
            if (sel_en)  en_q  <= wdata[PIN_N-1:0];
        end
    end

    assign clr = (we && sel_flg) ? wdata[PIN_N-1:0] : '0;

    always_comb begin
        rdata = '0;
        if (sel_pol)      rdata = {{PAD_W{1'b0}}, pol_q};
        else if (sel_en)  rdata = {{PAD_W{1'b0}}, en_q};
        else if (sel_flg) rdata = {{PAD_W{1'b0}}, flags};
    end

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
    parameter int         PIN_N       = 7,
    parameter int         DATA_W      = 8,
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] OFS_POL     = 8'h1D,
    parameter logic [7:0] OFS_EN      = 8'h1E,
    parameter logic [7:0] OFS_FLG     = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  pin_in,
    output logic              irq_o
);
    logic [PIN_N-1:0] pol_vec;
    logic [PIN_N-1:0] en_vec;
    logic [PIN_N-1:0] clr_vec;
    logic [PIN_N-1:0] hit_vec;
    logic [PIN_N-1:0] flag_vec;

    pin_irq_regs #(
        .PIN_N(PIN_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .OFS_POL(OFS_POL), .OFS_EN(OFS_EN), .OFS_FLG(OFS_FLG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
        .flags(flag_vec), .pol_q(pol_vec), .en_q(en_vec), .clr(clr_vec)
    );

    pin_irq_sync #(.PIN_N(PIN_N), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_raw(pin_in), .pol_rise(pol_vec), .hit(hit_vec)
    );

    for (genvar i = 0; i < PIN_N; i++) begin : g_flag
        pin_irq_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(hit_vec[i]), .clr_i(clr_vec[i]), .pend_o(flag_vec[i])
        );
    end

    assign irq_o = |(flag_vec & en_vec);

endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
    parameter int         PIN_N   = 7,
    parameter int         DATA_W  = 8,
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] OFS_FLG = 8'h1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [PIN_N-1:0]  flag_vec,
    input logic [PIN_N-1:0]  en_vec,
    input logic [PIN_N-1:0]  hit_vec
);
    logic flg_wr;
    assign flg_wr = bus_we && (bus_addr == ADDR_W'(OFS_FLG));

    // R9: an edge always leaves its flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |=> ((flag_vec & $past(hit_vec)) == $past(hit_vec)));

    // R8: write-1 clears every bit that had no edge
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flg_wr |=> ((flag_vec & $past(bus_wdata[PIN_N-1:0] & ~hit_vec)) == '0));

    // R8 / R10: without a flag write, no flag drops
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flg_wr |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    // R4 / R5: a flag rises only after an active edge
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_vec & ~$past(flag_vec) & ~$past(hit_vec)) == '0));

    // R6: nothing enabled, no request
    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> !irq_o);

    // R3: reserved read bit
    p_bit7_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1] == 1'b0);

endmodule

bind pin_edge_irq pin_irq_chk #(
    .PIN_N(PIN_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_FLG(OFS_FLG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .flag_vec(flag_vec), .en_vec(en_vec), .hit_vec(hit_vec)
);

// File: tb/test_pin_edge_irq.sv
`timescale 1ns/1ps
module test_pin_edge_irq;

    localparam logic [7:0] A_POL = 8'h1D;
    localparam logic [7:0] A_EN  = 8'h1E;
    localparam logic [7:0] A_FLG = 8'h1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] pin_in = '0;
    logic       irq_o;

    always #4 clk = ~clk;

    pin_edge_irq i_pin_edge_irq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_o(irq_o)
    );

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t q[$];
    logic rd_req = 1'b0;
    int   n_chk = 0;
    int   n_err = 0;
    logic done = 1'b0;

    // Driver: one read per cycle, expected item queued
    task automatic rd(input logic [7:0] a, input logic [7:0] d, input logic irq, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a;
        e.data = d; e.irq = irq; e.tag = tag;
        q.push_back(e);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pins_settle(input logic [6:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    // Monitor: compares just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rd_req) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (bus_rdata !== e.data || irq_o !== e.irq) begin
                    n_err++;
                    $display("FAIL %s: rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                             e.tag, bus_rdata, irq_o, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(A_POL, 8'h00, 1'b0, "R1 polarity reset");
        rd(A_EN,  8'h00, 1'b0, "R1 enable reset");
        rd(A_FLG, 8'h00, 1'b0, "R1 flag reset");

        wr(A_EN, 8'hFF);
        rd(A_EN, 8'h7F, 1'b0, "R3 enable bit7 reads 0");
        wr(A_EN, 8'h00);
        wr(A_POL, 8'hFF);
        rd(A_POL, 8'h7F, 1'b0, "R2 polarity bit7 reads 0");
        wr(A_POL, 8'h05);                   // pins 0,2 rising; others falling

        // R11 latency, R5 rising, R6 disabled latch
        @(negedge clk);
        pin_in = 7'h07;
        @(posedge clk); @(posedge clk);
        rd(A_FLG, 8'h00, 1'b0, "R11 not yet visible after edge 2");
        rd(A_FLG, 8'h05, 1'b0, "R5 R6 R11 rising pins latched, pin1 ignored");
        rd(A_FLG, 8'h05, 1'b0, "R10 read has no side effect");

        pins_settle(7'h05);                 // pin1 falls
        rd(A_FLG, 8'h07, 1'b0, "R4 falling edge sets flag");

        wr(A_EN, 8'h02);
        rd(A_FLG, 8'h07, 1'b1, "R7 enabled flag raises irq");
        wr(A_FLG, 8'h02);
        rd(A_FLG, 8'h05, 1'b0, "R8 write 1 clears, R7 irq drops");
        wr(A_FLG, 8'h00);
        rd(A_FLG, 8'h05, 1'b0, "R8 write 0 no effect");
        wr(A_FLG, 8'h78);
        rd(A_FLG, 8'h05, 1'b0, "R8 write never sets");

        pins_settle(7'h04);                 // pin0 falls, rising-armed: no event
        rd(A_FLG, 8'h05, 1'b0, "R5 falling ignored on rising pin");

        // R9: clear commits on the edge that sets the flag
        @(negedge clk);
        pin_in = 7'h05;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_addr = A_FLG; bus_wdata = 8'h01; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_FLG, 8'h05, 1'b0, "R9 set wins over clear");

        wr(A_FLG, 8'h05);
        rd(A_FLG, 8'h00, 1'b0, "R8 clear without edge");

        wr(A_POL, 8'h00);                   // all falling now
        wr(A_EN, 8'h04);
        rd(A_POL, 8'h00, 1'b0, "R2 polarity rewritten");
        pins_settle(7'h01);                 // pin2 falls
        rd(A_FLG, 8'h04, 1'b1, "R2 new polarity applies, R7 irq");
        wr(A_EN, 8'h00);
        rd(A_FLG, 8'h04, 1'b0, "R7 mask drops irq, flag kept");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule